// File: doc/BRIEF.md
# Diagnostic Serial Port with Self-Test Channel Modes

This block is an asynchronous serial transceiver for a debug console. Each character is eight data bits sent least significant bit first, framed by one low start bit and one high stop bit, with an optional parity bit between the data and the stop bit. A programmable divisor sets a baud tick at sixteen times the bit rate. The receiver finds the middle of each bit from that tick.

Software reaches the block through a small word-addressed register port. The port gives command, mode, divisor, interrupt-mask and status registers, and a shared data address. Writes to the data address fill the transmit holding register, and reads from it drain the receive holding register. Error flags stay set until software clears them. A channel-mode field reroutes the serial pins so that the transmitter and receiver can be tested with no external wiring. One registered interrupt line reports the masked status.

Top module: `dbg_uart`

## Requirements
- R1: One bit lasts 16*CD clock cycles, where CD is the divisor register (address 2). With CD = 0 no baud tick is produced, and a started frame stops progressing.
- R2: Transmit frame on the line: start bit 0, then data bit 0 through bit 7, then the parity bit when enabled, then stop bit 1. The line idles at 1.
- R3: The parity mode is mode register bits [2:0]: 0 even (the parity bit makes the count of ones even), 1 odd, 2 forced 0, 3 forced 1, 4 none. Values 5 to 7 are stored as 4.
- R4: Status register (address 6) bits are: 0 RX ready, 1 TX ready, 2 overrun, 3 framing error, 4 parity error, 5 TX empty. TX ready is high when the holding register is free. The holding register hands its character to the shifter while the shifter is idle, and TX ready then returns high. TX empty is high only when both the holding register and the shifter are idle.
- R5: When a received character completes, it goes to the receive holding register and RX ready is set. A read of address 7 clears RX ready.
- R6: If a character completes while RX ready is still set, the overrun flag is set and the newer character replaces the older one.
- R7: A wrong parity bit sets the parity-error flag. A low stop bit sets the framing-error flag. The overrun, framing and parity flags stay set until a command write with bit 6 set.
- R8: The receiver treats a low line as a start bit only if the line is still low 8 ticks later. Otherwise it returns to idle and delivers nothing.
- R9: The channel mode is mode register bits [5:4]. 0 normal: the transmitter drives TxD and RxD feeds the receiver. 1 echo: RxD is copied to TxD and the receiver still works. 2 local loopback: TxD is held at 1 and the transmitter feeds the receiver. 3 remote loopback: RxD is copied to TxD and the receiver sees an idle line.
- R10: Command register (address 0) bits are: 0 receiver reset, 1 receiver enable, 2 receiver disable, 3 transmitter reset, 4 transmitter enable, 5 transmitter disable. Disable wins over enable. A data write is accepted only while the transmitter is enabled and TX ready is high. A disabled receiver ignores the line. Transmitter reset aborts the frame and empties the holding register.
- R11: A write to address 3 sets mask bits and a write to address 4 clears them. The mask reads back at address 5. One cycle after the masked status becomes non-zero, irq_o is high, and it falls one cycle after the masked status becomes zero.
- R12: After reset both directions are disabled, CD = 0, the mode register reads 0x04, the mask is 0, the status reads 0x22, and txd_o and irq_o are 1 and 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 3 | Register word address |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe (side effect only at address 7) |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i (combinational) |
| rxd_i | input | 1 | Serial receive line |
| txd_o | output | 1 | Serial transmit line |
| irq_o | output | 1 | Interrupt request |

## Verification
A table of characters is looped back internally, each with its own parity mode: even, odd, both forced values and none. The data values are chosen so that a wrong parity rule or a wrong bit order shows up as a parity error or a corrupted byte. A normal-mode transmission is sampled at every bit centre, which checks bit order, odd parity and the 16*CD bit period. Frames driven onto the receive line carry a wrong parity bit, a low stop bit, or a short glitch in place of a start bit. These show whether each error flag and the start check respond only to their own fault. Echo, remote loopback, disabled directions and CD = 0 separate the pin routing from the receive path and the baud tick.

// File: rtl/dbg_uart_pkg.sv
package dbg_uart_pkg;
  localparam int CHAR_W = 8;
  localparam int OSR    = 16;
  localparam int MID    = OSR / 2;
  localparam int OSR_W  = $clog2(OSR);
  localparam int BIT_W  = $clog2(CHAR_W);
  localparam int ADDR_W = 3;
  localparam int ST_W   = 6;

  typedef enum logic [2:0] {
    PAR_EVEN = 3'd0, PAR_ODD = 3'd1, PAR_ZERO = 3'd2, PAR_ONE = 3'd3, PAR_NONE = 3'd4
  } par_mode_e;

  typedef enum logic [1:0] {
    CH_NORMAL = 2'd0, CH_ECHO = 2'd1, CH_LOCAL = 2'd2, CH_REMOTE = 2'd3
  } ch_mode_e;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_DATA, S_PAR, S_STOP
  } frame_st_e;

  localparam logic [ADDR_W-1:0] ADR_CMD   = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_MODE  = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_DIV   = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_IEN   = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_IDIS  = 3'd4;
  localparam logic [ADDR_W-1:0] ADR_IMASK = 3'd5;
  localparam logic [ADDR_W-1:0] ADR_STAT  = 3'd6;
  localparam logic [ADDR_W-1:0] ADR_DATA  = 3'd7;

  localparam int C_RX_RST = 0, C_RX_EN = 1, C_RX_DIS = 2;
  localparam int C_TX_RST = 3, C_TX_EN = 4, C_TX_DIS = 5;
  localparam int C_CLR_ST = 6;

  function automatic logic par_bit(par_mode_e m, logic [CHAR_W-1:0] d);
    case (m)
      PAR_EVEN: return ^d;
      PAR_ODD:  return ~^d;
      PAR_ONE:  return 1'b1;
      default:  return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/dbg_uart_baud.sv
module dbg_uart_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] cd_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if (cd_i == '0) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if (cnt_q >= cd_i - 1'b1) begin
      cnt_q  <= '0;
      tick_o <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
      tick_o <= 1'b0;
    end
  end

  assert_no_tick_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cd_i == '0) |=> !tick_o);
endmodule

// File: rtl/dbg_uart_tx.sv
module dbg_uart_tx
  import dbg_uart_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              clr_i,
  input  logic              load_i,
  input  logic [CHAR_W-1:0] data_i,
  input  par_mode_e         par_i,
  output logic              busy_o,
  output logic              line_o
);
  frame_st_e         st_q;
  logic [OSR_W-1:0]  cnt_q;
  logic [BIT_W-1:0]  idx_q;
  logic [CHAR_W-1:0] sh_q;
  logic              pb_q, pen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= S_IDLE;
      cnt_q <= '0;
      idx_q <= '0;
      sh_q  <= '0;
      pb_q  <= 1'b0;
      pen_q <= 1'b0;
    end else if (clr_i) begin
      st_q  <= S_IDLE;
      cnt_q <= '0;
    end else if (st_q == S_IDLE) begin
      if (load_i) begin
        sh_q  <= data_i;
        pb_q  <= par_bit(par_i, data_i);
        pen_q <= (par_i != PAR_NONE);
        st_q  <= S_START;
        cnt_q <= '0;
      end
    end else if (tick_i) begin
      if (cnt_q == OSR_W'(OSR-1)) begin
        cnt_q <= '0;
        case (st_q)
          S_START: begin
            st_q  <= S_DATA;
            idx_q <= '0;
          end
          S_DATA: begin
            sh_q <= sh_q >> 1;
            if (idx_q == BIT_W'(CHAR_W-1)) st_q <= pen_q ? S_PAR : S_STOP;
            else idx_q <= idx_q + 1'b1;
          end
          S_PAR:   st_q <= S_STOP;
          default: st_q <= S_IDLE;
        endcase
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  always_comb begin
    case (st_q)
      S_START: line_o = 1'b0;
      S_DATA:  line_o = sh_q[0];
      S_PAR:   line_o = pb_q;
      default: line_o = 1'b1;
    endcase
  end

  assign busy_o = (st_q != S_IDLE);
endmodule

// File: rtl/dbg_uart_rx.sv
module dbg_uart_rx
  import dbg_uart_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              clr_i,
  input  logic              en_i,
  input  logic              line_i,
  input  par_mode_e         par_i,
  output logic              done_o,
  output logic [CHAR_W-1:0] data_o,
  output logic              perr_o,
  output logic              ferr_o
);
  frame_st_e         st_q;
  logic [OSR_W-1:0]  cnt_q;
  logic [BIT_W-1:0]  idx_q;
  logic [CHAR_W-1:0] sh_q;
  logic              perr_q;
  logic              bit_end;

  assign bit_end = (cnt_q == OSR_W'(OSR-1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      cnt_q  <= '0;
      idx_q  <= '0;
      sh_q   <= '0;
      perr_q <= 1'b0;
      done_o <= 1'b0;
      data_o <= '0;
      perr_o <= 1'b0;
      ferr_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (clr_i || !en_i) begin
        st_q  <= S_IDLE;
        cnt_q <= '0;
      end else if (tick_i) begin
        case (st_q)
          S_IDLE: if (!line_i) begin
            st_q  <= S_START;
            cnt_q <= '0;
          end
          S_START: begin
            if (cnt_q == OSR_W'(MID-1)) begin
              cnt_q  <= '0;
              idx_q  <= '0;
              perr_q <= 1'b0;
              st_q   <= line_i ? S_IDLE : S_DATA;
            end else cnt_q <= cnt_q + 1'b1;
          end
          S_DATA: begin
            if (bit_end) begin
              cnt_q <= '0;
              sh_q  <= {line_i, sh_q[CHAR_W-1:1]};
              if (idx_q == BIT_W'(CHAR_W-1)) st_q <= (par_i != PAR_NONE) ? S_PAR : S_STOP;
              else idx_q <= idx_q + 1'b1;
            end else cnt_q <= cnt_q + 1'b1;
          end
          S_PAR: begin
            if (bit_end) begin
              cnt_q  <= '0;
              perr_q <= (line_i != par_bit(par_i, sh_q));
              st_q   <= S_STOP;
            end else cnt_q <= cnt_q + 1'b1;
          end
          default: begin
            if (bit_end) begin
              cnt_q  <= '0;
              done_o <= 1'b1;
              data_o <= sh_q;
              perr_o <= perr_q;
              ferr_o <= !line_i;
              st_q   <= S_IDLE;
            end else cnt_q <= cnt_q + 1'b1;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/dbg_uart.sv
module dbg_uart
  import dbg_uart_pkg::*;
#(
  parameter int DIV_W = 16,
  parameter int REG_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  input  logic              rxd_i,
  output logic              txd_o,
  output logic              irq_o
);
  logic              tx_en_q, rx_en_q;
  par_mode_e         par_q;
  ch_mode_e          ch_q;
  logic [DIV_W-1:0]  cd_q;
  logic [ST_W-1:0]   mask_q;
  logic [CHAR_W-1:0] thr_q, rhr_q;
  logic              thr_full_q, rx_rdy_q, ovr_q, perr_q, ferr_q;
  logic [1:0]        sync_q;

  logic tick, tx_busy, tx_line, tx_load, rx_done, rx_perr, rx_ferr;
  logic [CHAR_W-1:0] rx_data;
  logic wr_cmd, tx_clr, rx_clr, clr_st, thr_acc, rhr_rd, rx_src, tx_empty;
  logic [ST_W-1:0] status;

  assign wr_cmd  = wr_i && (addr_i == ADR_CMD);
  assign tx_clr  = wr_cmd && wdata_i[C_TX_RST];
  assign rx_clr  = wr_cmd && wdata_i[C_RX_RST];
  assign clr_st  = wr_cmd && wdata_i[C_CLR_ST];
  assign thr_acc = wr_i && (addr_i == ADR_DATA) && tx_en_q && !thr_full_q && !tx_clr;
  assign rhr_rd  = rd_i && (addr_i == ADR_DATA);
  assign tx_load = thr_full_q && !tx_busy && !tx_clr;
  assign tx_empty = !thr_full_q && !tx_busy;
  assign status  = {tx_empty, perr_q, ferr_q, ovr_q, !thr_full_q, rx_rdy_q};

  dbg_uart_baud #(.DIV_W(DIV_W)) i_baud (
    .clk_i, .rst_ni, .cd_i(cd_q), .tick_o(tick)
  );

  dbg_uart_tx i_tx (
    .clk_i, .rst_ni, .tick_i(tick), .clr_i(tx_clr), .load_i(tx_load),
    .data_i(thr_q), .par_i(par_q), .busy_o(tx_busy), .line_o(tx_line)
  );

  dbg_uart_rx i_rx (
    .clk_i, .rst_ni, .tick_i(tick), .clr_i(rx_clr), .en_i(rx_en_q),
    .line_i(sync_q[1]), .par_i(par_q), .done_o(rx_done), .data_o(rx_data),
    .perr_o(rx_perr), .ferr_o(rx_ferr)
  );

  // pin routing per channel mode
  always_comb begin
    case (ch_q)
      CH_ECHO:   begin txd_o = rxd_i;  rx_src = rxd_i;   end
      CH_LOCAL:  begin txd_o = 1'b1;   rx_src = tx_line; end
      CH_REMOTE: begin txd_o = rxd_i;  rx_src = 1'b1;    end
      default:   begin txd_o = tx_line; rx_src = rxd_i;  end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_en_q <= 1'b0;
      rx_en_q <= 1'b0;
      par_q   <= PAR_NONE;
      ch_q    <= CH_NORMAL;
      cd_q    <= '0;
      mask_q  <= '0;
      sync_q  <= 2'b11;
      irq_o   <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], rx_src};
      irq_o  <= |(status & mask_q);
      if (wr_cmd) begin
        if (wdata_i[C_TX_DIS])     tx_en_q <= 1'b0;
        else if (wdata_i[C_TX_EN]) tx_en_q <= 1'b1;
        if (wdata_i[C_RX_DIS])     rx_en_q <= 1'b0;
        else if (wdata_i[C_RX_EN]) rx_en_q <= 1'b1;
      end
      if (wr_i && addr_i == ADR_MODE) begin
        par_q <= (wdata_i[2:0] > 3'd4) ? PAR_NONE : par_mode_e'(wdata_i[2:0]);
        ch_q  <= ch_mode_e'(wdata_i[5:4]);
      end
      if (wr_i && addr_i == ADR_DIV)  cd_q   <= wdata_i[DIV_W-1:0];
      if (wr_i && addr_i == ADR_IEN)  mask_q <= mask_q | wdata_i[ST_W-1:0];
      if (wr_i && addr_i == ADR_IDIS) mask_q <= mask_q & ~wdata_i[ST_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      thr_q      <= '0;
      thr_full_q <= 1'b0;
    end else if (tx_clr) begin
      thr_full_q <= 1'b0;
    end else if (thr_acc) begin
      thr_q      <= wdata_i[CHAR_W-1:0];
      thr_full_q <= 1'b1;
    end else if (tx_load) begin
      thr_full_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rhr_q    <= '0;
      rx_rdy_q <= 1'b0;
      ovr_q    <= 1'b0;
      perr_q   <= 1'b0;
      ferr_q   <= 1'b0;
    end else begin
      ovr_q  <= (ovr_q  && !clr_st) || (rx_done && rx_rdy_q);
      perr_q <= (perr_q && !clr_st) || (rx_done && rx_perr);
      ferr_q <= (ferr_q && !clr_st) || (rx_done && rx_ferr);
      if (rx_done) rhr_q <= rx_data;
      if (rx_clr)       rx_rdy_q <= 1'b0;
      else if (rx_done) rx_rdy_q <= 1'b1;
      else if (rhr_rd)  rx_rdy_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADR_MODE:  rdata_o = REG_W'({ch_q, 1'b0, par_q});
      ADR_DIV:   rdata_o = REG_W'(cd_q);
      ADR_IMASK: rdata_o = REG_W'(mask_q);
      ADR_STAT:  rdata_o = REG_W'(status);
      ADR_DATA:  rdata_o = REG_W'(rhr_q);
      default:   rdata_o = '0;
    endcase
  end

  assert_empty_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_empty |-> tx_line);
  assert_accept_blocks_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    thr_acc |=> !tx_empty);
  assert_read_clears_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rhr_rd && !rx_done && !rx_clr) |=> !rx_rdy_q);
  assert_no_overflow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_done && rx_rdy_q) |=> ovr_q);
  assert_sticky_ferr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ferr_q && !clr_st) |=> ferr_q);
endmodule

// File: tb/test_dbg_uart.sv
`timescale 1ns/1ps
module test_dbg_uart;
  localparam int CD  = 2;
  localparam int BIT = 16 * CD;
  // {parity mode[2:0], data[7:0]}
  localparam logic [10:0] VEC [6] = '{11'h04B, 11'h100, 11'h2FF, 11'h381, 11'h45A, 11'h07E};

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [2:0]  addr = '0;
  logic        wr = 1'b0, rd = 1'b0, rxd = 1'b1;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        txd, irq;
  int n_chk = 0, n_fail = 0;
  logic [15:0] v;
  logic        low_seen = 1'b0, mon_en = 1'b0;

  always #4 clk = ~clk;

  dbg_uart i_dbg_uart (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .rxd_i(rxd), .txd_o(txd), .irq_o(irq)
  );

  always @(negedge clk) if (mon_en && !txd) low_seen <= 1'b1;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wreg(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rreg(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; rd = 1'b1; #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic wait_flag(input int b, input int maxc);
    logic [15:0] s;
    for (int i = 0; i < maxc; i++) begin
      rreg(3'd6, s);
      if (s[b]) return;
    end
  endtask

  function automatic logic exp_par(input logic [2:0] m, input logic [7:0] d);
    int ones = 0;
    for (int i = 0; i < 8; i++) ones += int'(d[i]);
    case (m)
      3'd0: return (ones % 2) == 1;
      3'd1: return (ones % 2) == 0;
      3'd3: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic drive_bit(input logic b);
    rxd = b;
    repeat (BIT) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input logic use_p, input logic pb, input logic stopv);
    @(negedge clk);
    drive_bit(1'b0);
    for (int i = 0; i < 8; i++) drive_bit(d[i]);
    if (use_p) drive_bit(pb);
    drive_bit(stopv);
    drive_bit(1'b1);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R12 reset state
    rreg(3'd6, v); chk("R12 status", v, 16'h0022);
    rreg(3'd1, v); chk("R12 mode", v, 16'h0004);
    rreg(3'd2, v); chk("R12 divisor", v, 16'h0000);
    chk("R12 txd", {15'd0, txd}, 16'd1);
    chk("R12 irq", {15'd0, irq}, 16'd0);

    wreg(3'd2, CD);
    wreg(3'd0, 16'h0012);

    // R2 R3 R9: table of characters in local loopback
    mon_en = 1'b1;
    for (int k = 0; k < 6; k++) begin
      wreg(3'd1, {10'd0, 2'd2, 1'b0, VEC[k][10:8]});
      wreg(3'd7, {8'd0, VEC[k][7:0]});
      wait_flag(0, 1000);
      rreg(3'd6, v); chk("R3 no errors in loopback", v & 16'h001D, 16'h0001);
      rreg(3'd7, v); chk("R2 loopback data", v, {8'd0, VEC[k][7:0]});
      rreg(3'd6, v); chk("R5 read clears RX ready", {15'd0, v[0]}, 16'd0);
    end
    mon_en = 1'b0;
    chk("R9 local loopback keeps txd high", {15'd0, low_seen}, 16'd0);

    // R4 R6 R7: two characters back to back, overrun
    wreg(3'd1, 16'h0024);
    wreg(3'd7, 16'h00C3);
    rreg(3'd6, v); chk("R4 TX ready after hand-off", {15'd0, v[1]}, 16'd1);
    wreg(3'd7, 16'h003C);
    rreg(3'd6, v); chk("R4 holding full", {14'd0, v[5], v[1]}, 16'd0);
    wait_flag(5, 2000);
    repeat (10) @(negedge clk);
    rreg(3'd6, v); chk("R6 overrun set", {15'd0, v[2]}, 16'd1);
    rreg(3'd7, v); chk("R6 newest character kept", v, 16'h003C);
    rreg(3'd6, v); chk("R7 overrun sticky", {15'd0, v[2]}, 16'd1);
    wreg(3'd0, 16'h0040);
    rreg(3'd6, v); chk("R7 clear status", v & 16'h001C, 16'h0000);

    // R11 interrupt
    wreg(3'd3, 16'h0001);
    rreg(3'd5, v); chk("R11 mask readback", v, 16'h0001);
    chk("R11 irq low", {15'd0, irq}, 16'd0);
    wreg(3'd7, 16'h0099);
    wait_flag(0, 1000);
    repeat (2) @(negedge clk);
    chk("R11 irq high", {15'd0, irq}, 16'd1);
    wreg(3'd4, 16'h0001);
    repeat (2) @(negedge clk);
    chk("R11 irq masked", {15'd0, irq}, 16'd0);
    rreg(3'd7, v);

    // R1 R2 R3: normal mode transmit waveform, odd parity
    wreg(3'd1, 16'h0001);
    wreg(3'd7, 16'h00A5);
    @(negedge txd);
    repeat (BIT / 2) @(negedge clk);
    chk("R2 start bit", {15'd0, txd}, 16'd0);
    for (int i = 0; i < 8; i++) begin
      repeat (BIT) @(negedge clk);
      chk("R1 R2 data bit", {15'd0, txd}, {15'd0, 1'(8'hA5 >> i)});
    end
    repeat (BIT) @(negedge clk);
    chk("R3 odd parity bit", {15'd0, txd}, {15'd0, exp_par(3'd1, 8'hA5)});
    repeat (BIT) @(negedge clk);
    chk("R2 stop bit", {15'd0, txd}, 16'd1);
    wait_flag(5, 1000);

    // R7 parity error on receive, even mode
    wreg(3'd1, 16'h0000);
    send_frame(8'h4B, 1'b1, ~exp_par(3'd0, 8'h4B), 1'b1);
    wait_flag(0, 500);
    rreg(3'd6, v); chk("R7 parity error only", v & 16'h001C, 16'h0010);
    rreg(3'd7, v); chk("R5 data with parity error", v, 16'h004B);
    wreg(3'd0, 16'h0040);

    // R7 framing error, no parity
    wreg(3'd1, 16'h0004);
    send_frame(8'h66, 1'b0, 1'b0, 1'b0);
    wait_flag(0, 500);
    rreg(3'd6, v); chk("R7 framing error only", v & 16'h001C, 16'h0008);
    rreg(3'd7, v);
    wreg(3'd0, 16'h0040);

    // R8 short glitch rejected
    @(negedge clk); rxd = 1'b0;
    repeat (4 * CD) @(negedge clk); rxd = 1'b1;
    repeat (20 * BIT) @(negedge clk);
    rreg(3'd6, v); chk("R8 glitch rejected", v & 16'h001D, 16'h0000);

    // R9 echo mode
    wreg(3'd1, 16'h0014);
    @(negedge clk); rxd = 1'b0; #1;
    chk("R9 echo low", {15'd0, txd}, 16'd0);
    rxd = 1'b1; #1;
    chk("R9 echo high", {15'd0, txd}, 16'd1);
    send_frame(8'h3C, 1'b0, 1'b0, 1'b1);
    wait_flag(0, 500);
    rreg(3'd7, v); chk("R9 echo receiver works", v, 16'h003C);

    // R9 remote loopback
    wreg(3'd1, 16'h0034);
    @(negedge clk); rxd = 1'b0; #1;
    chk("R9 remote follows rxd", {15'd0, txd}, 16'd0);
    rxd = 1'b1;
    send_frame(8'h55, 1'b0, 1'b0, 1'b1);
    rreg(3'd6, v); chk("R9 remote isolates receiver", {15'd0, v[0]}, 16'd0);

    // R10 receiver disabled
    wreg(3'd1, 16'h0004);
    wreg(3'd0, 16'h0004);
    send_frame(8'h81, 1'b0, 1'b0, 1'b1);
    rreg(3'd6, v); chk("R10 disabled receiver", {15'd0, v[0]}, 16'd0);
    wreg(3'd0, 16'h0002);

    // R10 transmitter disabled drops write
    wreg(3'd0, 16'h0020);
    wreg(3'd7, 16'h0011);
    rreg(3'd6, v); chk("R10 write ignored", {14'd0, v[5], v[1]}, 16'h0003);
    wreg(3'd0, 16'h0010);
    mon_en = 1'b1; low_seen = 1'b0;
    repeat (400) @(negedge clk);
    mon_en = 1'b0;
    chk("R10 nothing sent", {15'd0, low_seen}, 16'd0);

    // R1 R10 divisor zero stalls; transmitter reset recovers
    wreg(3'd2, 16'h0000);
    wreg(3'd7, 16'h0022);
    repeat (2) @(negedge clk);
    rreg(3'd6, v); chk("R1 hand-off without tick", {14'd0, v[5], v[1]}, 16'h0001);
    repeat (500) @(negedge clk);
    rreg(3'd6, v); chk("R1 stalled with CD=0", {15'd0, v[5]}, 16'd0);
    chk("R1 stalled in start bit", {15'd0, txd}, 16'd0);
    wreg(3'd0, 16'h0008);
    rreg(3'd6, v); chk("R10 transmitter reset", {15'd0, v[5]}, 16'd1);
    chk("R10 line idle after reset", {15'd0, txd}, 16'd1);

    summary();
    $finish;
  end
endmodule